// File: doc/BRIEF.md
# Cache Line Content-Type Compression Selector

This block sits at the insertion port of a compressed last-level cache. Whenever a line enters the cache, whether written back from a private cache or filled from memory, the block inspects the 512-bit line. It treats the line as eight independent 64-bit words and guesses the kind of data each word holds from its bit patterns. From those guesses it picks one compression method identifier for the whole line. The compressor that follows uses this identifier. The block does not compress anything itself; it only predicts and selects.

The work is split into two pipeline stages. The first stage classifies every word and registers the eight type codes. The second stage counts the codes, chooses the method by majority with a fixed tie order, and drives the results together with a one-cycle done strobe. A new line may be offered on every cycle.

Top module: `cl_method_select`

## Requirements
- R1: Word i of the line is bits [64*i+63 : 64*i], and its type code is reported on out_types[2*i+1 : 2*i].
- R2: A word whose 64 bits are all zero gets type code 2'b00 (zero).
- R3: A word that is not all zero, and whose bits 63..32 all equal bit 31, gets type code 2'b01 (small integer). A word with bit 31 set and bits 63..32 clear is not of this type.
- R4: A word that is neither zero nor small integer, and whose bits 63..48 equal ptr_base, gets type code 2'b10 (pointer-like).
- R5: Every other word gets type code 2'b11 (floating point).
- R6: The method is chosen by the most frequent type among the eight words. The codes are 3'd1 for zero, 3'd2 for small integer (base-delta coding), 3'd3 for pointer (upper-bits dictionary) and 3'd4 for floating point (semantic bit-field coding).
- R7: When two or more types share the highest count, the tie goes to zero first, then small integer, then pointer, then floating point.
- R8: A line whose eight words are all zero selects method 3'd7, whatever the other rules give.
- R9: out_done is high for exactly one cycle, two clock cycles after each cycle in which in_valid is high. Lines offered on consecutive cycles each produce their own strobe, in order.
- R10: After reset, out_done, out_types and out_method are zero. Between strobes, out_types and out_method hold the values of the last completed line.
- R11: A line presented while in_valid is low is ignored. It produces no strobe and does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A line is being inserted this cycle |
| in_line | input | 512 | Cache line contents, word 0 in the low bits |
| ptr_base | input | 16 | Upper bits that mark a pointer-like word, sampled with the line |
| out_types | output | 16 | Two-bit type code for each of the eight words |
| out_method | output | 3 | Selected compression method code |
| out_done | output | 1 | One-cycle strobe: out_types and out_method are new |

## Verification
The type codes and the method code both appear in the same cycle as the strobe. That cycle comes two rising edges after the edge that samples in_valid, and nothing is due at the first edge. The bench drives each line on a falling edge. One falling edge later it confirms that no strobe has appeared yet. One falling edge after that it compares the strobe, the types and the method against its reference functions. On the following falling edge it checks that the strobe has dropped and the outputs are held. For lines offered back to back, each result is expected one cycle after the previous one.

// File: rtl/cms_pkg.sv
// Shared encodings for the content-type compression selector.
// Assumes 2-bit word types and 3-bit method identifiers.
package cms_pkg;
    typedef enum logic [1:0] {
        T_ZERO  = 2'b00,
        T_INT   = 2'b01,
        T_PTR   = 2'b10,
        T_FLOAT = 2'b11
    } wtype_e;

    localparam int METHOD_W = 3;
    localparam logic [METHOD_W-1:0] M_NONE     = 3'd0;
    localparam logic [METHOD_W-1:0] M_ZERO     = 3'd1;
    localparam logic [METHOD_W-1:0] M_DELTA    = 3'd2;
    localparam logic [METHOD_W-1:0] M_PTRDICT  = 3'd3;
    localparam logic [METHOD_W-1:0] M_BITFIELD = 3'd4;
    localparam logic [METHOD_W-1:0] M_ZLINE    = 3'd7;
endpackage

// File: rtl/cms_word_classify.sv
// Combinational type guess for one word.
// Checks run in priority order: zero, sign-extended small integer,
// pointer with matching upper bits, otherwise floating point.
// Assumes INT_LO < WORD_W and PTR_BITS <= WORD_W.
module cms_word_classify #(
    parameter int WORD_W   = 64,
    parameter int INT_LO   = 32,
    parameter int PTR_BITS = 16
) (
    input  logic [WORD_W-1:0]   word,
    input  logic [PTR_BITS-1:0] base,
    output logic [1:0]          kind
);
    import cms_pkg::*;

    localparam int EXT_W = WORD_W - INT_LO + 1;

    logic [EXT_W-1:0] ext_bits;
    logic             is_zero;
    logic             is_int;
    logic             is_ptr;

    // Pattern detectors for the word.
    always_comb begin
        ext_bits = word[WORD_W-1:INT_LO-1];
        is_zero  = ~|word;
        is_int   = (&ext_bits) | (~|ext_bits);
        is_ptr   = (word[WORD_W-1:WORD_W-PTR_BITS] == base);
    end

    // Priority encode the detectors into a type code.
    always_comb begin
        if (is_zero)     kind = T_ZERO;
        else if (is_int) kind = T_INT;
        else if (is_ptr) kind = T_PTR;
        else             kind = T_FLOAT;
    end
endmodule

// File: rtl/cms_inspect.sv
// Stage one: classifies every word of the incoming line and registers
// the packed type codes together with a valid flag.
// Assumes the line is NWORDS words of WORD_W bits, word 0 lowest.
module cms_inspect #(
    parameter int NWORDS   = 8,
    parameter int WORD_W   = 64,
    parameter int INT_LO   = 32,
    parameter int PTR_BITS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NWORDS*WORD_W-1:0] in_line,
    input  logic [PTR_BITS-1:0]      ptr_base,
    output logic [2*NWORDS-1:0]      types_q,
    output logic                     valid_q
);
    logic [2*NWORDS-1:0] types_d;

    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        cms_word_classify #(
            .WORD_W  (WORD_W),
            .INT_LO  (INT_LO),
            .PTR_BITS(PTR_BITS)
        ) u_cls (
            .word(in_line[gi*WORD_W +: WORD_W]),
            .base(ptr_base),
            .kind(types_d[2*gi +: 2])
        );
    end

    // Capture type codes only for inserted lines; flag them for stage two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            types_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) types_q <= types_d;
        end
    end
endmodule

// File: rtl/cms_select.sv
// Stage two: counts the type codes, picks the majority type with ties
// going to the lower code, maps it to a method, and registers results.
// A line made only of zero words selects the dedicated zero-line method.
module cms_select #(
    parameter int NWORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s1_valid,
    input  logic [2*NWORDS-1:0]          s1_types,
    output logic [2*NWORDS-1:0]          out_types,
    output logic [cms_pkg::METHOD_W-1:0] out_method,
    output logic                         out_done
);
    import cms_pkg::*;

    localparam int CNT_W  = $clog2(NWORDS + 1);
    localparam int NTYPES = 4;

    logic [CNT_W-1:0]    cnt [NTYPES];
    logic [1:0]          best;
    logic [METHOD_W-1:0] method_d;

    // Histogram of type codes across the line.
    always_comb begin
        for (int k = 0; k < NTYPES; k++) cnt[k] = '0;
        for (int i = 0; i < NWORDS; i++)
            cnt[s1_types[2*i +: 2]] = cnt[s1_types[2*i +: 2]] + CNT_W'(1);
    end

    // Strictly-greater scan so that earlier (higher priority) types win ties.
    always_comb begin
        best = 2'd0;
        for (int k = 1; k < NTYPES; k++)
            if (cnt[k] > cnt[best]) best = 2'(k);
    end

    // Method mapping with the all-zero override.
    always_comb begin
        if (cnt[0] == CNT_W'(NWORDS)) method_d = M_ZLINE;
        else                          method_d = METHOD_W'(best) + M_ZERO;
    end

    // Output registers: refresh on a completed line, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_types  <= '0;
            out_method <= M_NONE;
            out_done   <= 1'b0;
        end else begin
            out_done <= s1_valid;
            if (s1_valid) begin
                out_types  <= s1_types;
                out_method <= method_d;
            end
        end
    end
endmodule

// File: rtl/cl_method_select.sv
// Top of the content-type compression selector: a two-stage pipeline
// (inspect, then select) with one result per inserted line.
// Assumes ptr_base is valid in the same cycle as the line.
module cl_method_select #(
    parameter int NWORDS   = 8,
    parameter int WORD_W   = 64,
    parameter int INT_LO   = 32,
    parameter int PTR_BITS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NWORDS*WORD_W-1:0] in_line,
    input  logic [PTR_BITS-1:0]      ptr_base,
    output logic [2*NWORDS-1:0]      out_types,
    output logic [2:0]               out_method,
    output logic                     out_done
);
    logic [2*NWORDS-1:0] s1_types;
    logic                s1_valid;

    cms_inspect #(
        .NWORDS  (NWORDS),
        .WORD_W  (WORD_W),
        .INT_LO  (INT_LO),
        .PTR_BITS(PTR_BITS)
    ) u_inspect (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_line (in_line),
        .ptr_base(ptr_base),
        .types_q (s1_types),
        .valid_q (s1_valid)
    );

    cms_select #(
        .NWORDS(NWORDS)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_types  (s1_types),
        .out_types (out_types),
        .out_method(out_method),
        .out_done  (out_done)
    );
endmodule

// File: rtl/cms_checker.sv
// Property checker for the selector, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module cms_checker #(
    parameter int NWORDS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2*NWORDS-1:0] out_types,
    input logic [2:0]          out_method,
    input logic                out_done
);
    AST_DONE_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 out_done); // R9
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) out_done |-> $past(in_valid, 2)); // R11
    AST_ZERO_LINE_CODE: assert property (@(posedge clk) disable iff (!rst_n) (out_done && out_types == '0) |-> out_method == 3'd7); // R8
    AST_ALL_FLOAT_CODE: assert property (@(posedge clk) disable iff (!rst_n) (out_done && out_types == {NWORDS{2'b11}}) |-> out_method == 3'd4); // R6
    AST_METHOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_done |-> (out_method inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7})); // R6
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !out_done |-> ($stable(out_method) && $stable(out_types))); // R10
endmodule

bind cl_method_select cms_checker #(.NWORDS(NWORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_types (out_types),
    .out_method(out_method),
    .out_done  (out_done)
);

// File: tb/sim_cl_method_select.sv
`timescale 1ns/1ps
module sim_cl_method_select;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] in_line = '0;
    logic [15:0]  ptr_base = '0;
    logic [15:0]  out_types;
    logic [2:0]   out_method;
    logic         out_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cl_method_select u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
        .ptr_base(ptr_base), .out_types(out_types), .out_method(out_method),
        .out_done(out_done)
    );

    function automatic logic [1:0] ref_type(logic [63:0] w, logic [15:0] b);
        if (w == 64'd0) return 2'b00;
        if (w[63:31] == '0 || w[63:31] == '1) return 2'b01;
        if (w[63:48] == b) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [15:0] ref_types(logic [511:0] ln, logic [15:0] b);
        logic [15:0] t;
        for (int i = 0; i < 8; i++) t[2*i +: 2] = ref_type(ln[64*i +: 64], b);
        return t;
    endfunction

    function automatic logic [2:0] ref_method(logic [15:0] t);
        int c [4];
        int best;
        for (int k = 0; k < 4; k++) c[k] = 0;
        for (int i = 0; i < 8; i++) c[t[2*i +: 2]]++;
        if (c[0] == 8) return 3'd7;
        best = 0;
        for (int k = 1; k < 4; k++) if (c[k] > c[best]) best = k;
        return 3'(best + 1);
    endfunction

    task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Offer one line, then check the strobe timing and results.
    task automatic run_line(logic [511:0] ln, logic [15:0] b, string rq);
        logic [15:0] et;
        et = ref_types(ln, b);
        @(negedge clk); in_line = ln; ptr_base = b; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check("R9 early", 64'(out_done), 64'd0);
        @(negedge clk);
        check("R9 due", 64'(out_done), 64'd1);
        check("R1 types", 64'(out_types), 64'(et));
        check(rq, 64'(out_method), 64'(ref_method(et)));
        @(negedge clk);
        check("R9 single", 64'(out_done), 64'd0);
        check("R10 hold", 64'(out_method), 64'(ref_method(et)));
    endtask

    function automatic logic [511:0] pack8(logic [63:0] w0, logic [63:0] w1, logic [63:0] w2,
                                           logic [63:0] w3, logic [63:0] w4, logic [63:0] w5,
                                           logic [63:0] w6, logic [63:0] w7);
        return {w7, w6, w5, w4, w3, w2, w1, w0};
    endfunction

    function automatic logic [63:0] rand_word(logic [15:0] b);
        logic [63:0] w;
        w = {$urandom, $urandom};
        case ($urandom_range(0, 3))
            0: w = 64'd0;
            1: w = {{32{w[31]}}, w[31:0]};
            2: w = {b, w[47:0]};
            default: ;
        endcase
        return w;
    endfunction

    localparam logic [63:0] ZW = 64'd0;
    localparam logic [63:0] IN = 64'hFFFF_FFFF_FFFF_FFF0;
    localparam logic [63:0] IP = 64'h0000_0000_0000_0005;
    localparam logic [63:0] FL = 64'h3FF0_0000_0000_0000;
    localparam logic [15:0] BS = 16'h7F12;
    localparam logic [63:0] PT = {16'h7F12, 48'h1234_5678_9ABC};

    initial begin
        logic [511:0] ln;
        logic [15:0]  b;
        logic [15:0]  held_t;
        logic [2:0]   held_m;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10 reset done", 64'(out_done), 64'd0);
        check("R10 reset types", 64'(out_types), 64'd0);
        check("R10 reset method", 64'(out_method), 64'd0);
        rst_n = 1'b1;

        // R2 R8: all-zero line.
        run_line('0, BS, "R8 zero line");
        // R5 R6: all floats.
        run_line({8{FL}}, BS, "R6 float");
        // R7: 2/2/2/2 tie goes to zero.
        run_line(pack8(ZW, ZW, IN, IP, PT, PT, FL, FL), BS, "R7 tie zero");
        // R7: int vs pointer tie goes to int.
        run_line(pack8(IN, IP, IN, PT, PT, PT, FL, FL), BS, "R7 tie int");
        // R7: pointer vs float tie goes to pointer.
        run_line(pack8(PT, PT, PT, PT, FL, FL, FL, FL), BS, "R7 tie ptr");
        // R6: zero majority without full zero line.
        run_line(pack8(ZW, ZW, ZW, ZW, ZW, ZW, ZW, FL), BS, "R6 zero major");
        // R3 boundary: bit 31 set without sign extension is not an integer.
        run_line({8{64'h0000_0000_8000_0000}}, BS, "R3 float boundary");
        // R3 R4 boundary: upper ones but bit 31 clear, matched to the base.
        run_line({8{64'hFFFF_FFFF_7FFF_FFFF}}, 16'hFFFF, "R4 pointer boundary");
        // R1: single distinct word in each position.
        for (int p = 0; p < 8; p++) begin
            ln = {8{FL}};
            ln[64*p +: 64] = PT;
            run_line(ln, BS, "R1 position");
        end

        // R9: back-to-back lines each produce their own strobe.
        @(negedge clk); in_line = {8{IN}}; ptr_base = BS; in_valid = 1'b1;
        @(negedge clk); in_line = {8{PT}};
        @(negedge clk); in_valid = 1'b0;
        check("R9 b2b first", 64'(out_done), 64'd1);
        check("R6 b2b first", 64'(out_method), 64'd2);
        @(negedge clk);
        check("R9 b2b second", 64'(out_done), 64'd1);
        check("R6 b2b second", 64'(out_method), 64'd3);
        @(negedge clk);
        check("R9 b2b end", 64'(out_done), 64'd0);

        // R11: lines without valid change nothing.
        held_t = out_types;
        held_m = out_method;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk); in_line = '0; ptr_base = $urandom;
            check("R11 no strobe", 64'(out_done), 64'd0);
            check("R11 types held", 64'(out_types), 64'(held_t));
            check("R11 method held", 64'(out_method), 64'(held_m));
        end

        // Constrained random lines.
        for (int n = 0; n < 300; n++) begin
            b = 16'($urandom);
            for (int i = 0; i < 8; i++) ln[64*i +: 64] = rand_word(b);
            run_line(ln, b, "R6 R7 random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule